// File: doc/BRIEF.md
# Structured VDM Identity Responder

This block is the policy engine of a cable plug for vendor-defined messages. The receive path hands it a request as a series of 32-bit data objects, with the first object marked as the header. The block decodes that header and decides whether to answer. A structured Discover Identity request from an initiator, addressed to the PD SID, gets an acknowledge stream. The stream holds the response header followed by the identity objects, which come from a four-entry register file. Any other structured initiator request gets a single negative-acknowledge header.

The register file holds the ID header, the certification object, the product object and the cable object. It is loaded through a simple write port that stands in for nonvolatile storage. Response objects leave one per clock cycle, flagged first and last, with the object count of the whole response alongside. Message-header and CRC generation are left to the transmit path.

Top module: `vdm_id_responder`

## Requirements
- R1: After reset and while idle, `tx_valid_o` is low.
- R2: A header object with bit 15 = 0 (unstructured) produces no response and has no effect on a response already streaming.
- R3: A structured header whose command type, bits 7:6, is not 00 (initiator) is dropped with no response and no effect on a response already streaming.
- R4: A structured initiator header with SVID (bits 31:16) = 16'hFF00 and command (bits 4:0) = 1 is acknowledged. The stream is the response header, then register 0 (ID header), register 1 (cert), register 2 (product), then register 3 (cable) when present.
- R5: Every response header carries the request SVID in 31:16 and the request command in 4:0. Bit 15 is 1, and bits 14:13, 12:11, 10:8 and 5 are zero. Bits 7:6 are 01 for ACK and 10 for NAK.
- R6: An acknowledge has 5 objects when the ID header product type (bits 29:27) is 011 or 100, and 4 objects otherwise. `tx_count_o` shows this total on every beat.
- R7: A structured initiator request with any other command, or with an SVID other than 16'hFF00, is answered by one NAK header with `tx_count_o` = 1.
- R8: Register writes force ID header bits 25:16, cert bits 31:20 and cable bits 23:20 to zero. Register addresses are 0 ID header, 1 cert, 2 product, 3 cable.
- R9: The first response object appears in the cycle after the header is accepted. The stream then advances one object per cycle, with `tx_first_o` on the first beat and `tx_last_o` on the last.
- R10: An answered request that arrives while a response is streaming aborts the remainder of that response. The new response starts in the next cycle.
- R11: No response header ever carries command type 00 (initiator).
- R12: Objects presented with `rx_first_i` low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Request object valid |
| rx_first_i | input | 1 | Object is the request header |
| rx_data_i | input | 32 | Request object |
| cfg_we_i | input | 1 | Register file write enable |
| cfg_addr_i | input | 2 | Register select |
| cfg_wdata_i | input | 32 | Register write data |
| tx_valid_o | output | 1 | Response object valid |
| tx_first_o | output | 1 | First response object |
| tx_last_o | output | 1 | Last response object |
| tx_data_o | output | 32 | Response object |
| tx_count_o | output | 3 | Total objects in this response |

## Verification
Two events can land on the same clock edge: the natural end of a response stream and the acceptance of a new header. The bench provokes this in two ways. In one case a request is timed to arrive exactly on the edge that ends a five-object stream, so the new response must follow without a gap. In the other it arrives one edge earlier, so the last cable object must never appear. A second collision drives dropped headers into a live stream. The scoreboard then expects the stream to complete untouched, because any stray, missing or reordered object shows up as a mismatch or an unexpected pop.

// File: rtl/vdm_id_pkg.sv
package vdm_id_pkg;

  typedef enum logic [1:0] {
    CT_REQ  = 2'b00,
    CT_ACK  = 2'b01,
    CT_NAK  = 2'b10,
    CT_BUSY = 2'b11
  } cmd_type_e;

  typedef struct packed {
    logic [15:0] svid;
    logic        structured;
    logic [1:0]  ver;
    logic [1:0]  rsv_hi;
    logic [2:0]  obj_pos;
    cmd_type_e   ctype;
    logic        rsv_lo;
    logic [4:0]  cmd;
  } vdm_hdr_t;

  localparam logic [4:0] CMD_DISC_ID = 5'd1;

  localparam logic [31:0] MASK_ID    = 32'hFC00_FFFF;
  localparam logic [31:0] MASK_CERT  = 32'h000F_FFFF;
  localparam logic [31:0] MASK_PROD  = 32'hFFFF_FFFF;
  localparam logic [31:0] MASK_CABLE = 32'hFF0F_FFFF;

  function automatic logic [31:0] reg_mask(input int idx);
    case (idx)
      0:       return MASK_ID;
      1:       return MASK_CERT;
      2:       return MASK_PROD;
      default: return MASK_CABLE;
    endcase
  endfunction

  function automatic logic is_cable(input logic [2:0] ptype);
    return (ptype == 3'b011) || (ptype == 3'b100);
  endfunction

endpackage

// File: rtl/vdm_hdr_decode.sv
module vdm_hdr_decode
  import vdm_id_pkg::*;
#(
  parameter logic [15:0] PD_SID = 16'hFF00
) (
  input  logic        valid_i,
  input  logic        first_i,
  input  logic [31:0] data_i,
  output logic        answer_o,
  output logic        ack_o,
  output vdm_hdr_t    resp_o
);

  vdm_hdr_t req;
  logic     unused_fields;

  assign req = vdm_hdr_t'(data_i);
  assign unused_fields = ^{req.ver, req.rsv_hi, req.obj_pos, req.rsv_lo};

  always_comb begin
    answer_o = valid_i && first_i && req.structured && (req.ctype == CT_REQ);
    ack_o    = (req.svid == PD_SID) && (req.cmd == CMD_DISC_ID);
    resp_o            = '0;
    resp_o.svid       = req.svid;
    resp_o.structured = 1'b1;
    resp_o.ctype      = ack_o ? CT_ACK : CT_NAK;
    resp_o.cmd        = req.cmd;
  end

endmodule

// File: rtl/vdm_id_regs.sv
module vdm_id_regs
  import vdm_id_pkg::*;
#(
  parameter int ADDR_W = 2,
  localparam int NUM_REGS = 1 << ADDR_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [31:0]               wdata_i,
  output logic [NUM_REGS-1:0][31:0] regs_o
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [31:0] MASK = reg_mask(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_o[g] <= '0;
      else if (we_i && addr_i == ADDR_W'(g))     regs_o[g] <= wdata_i & MASK;
    end
  end

  p_id_rsv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == '0 |=> regs_o[0][25:16] == '0);

  p_cert_rsv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == ADDR_W'(1) |=> regs_o[1][31:20] == '0);

endmodule

// File: rtl/vdm_resp_seq.sv
module vdm_resp_seq
  import vdm_id_pkg::*;
#(
  parameter int NUM_REGS = 4,
  localparam int CNT_W = $clog2(NUM_REGS + 2)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      ack_i,
  input  logic                      cable_i,
  input  vdm_hdr_t                  hdr_i,
  input  logic [NUM_REGS-1:0][31:0] regs_i,
  output logic                      tx_valid_o,
  output logic                      tx_first_o,
  output logic                      tx_last_o,
  output logic [31:0]               tx_data_o,
  output logic [CNT_W-1:0]          tx_count_o
);

  logic             active_q;
  logic [CNT_W-1:0] idx_q, cnt_q;
  vdm_hdr_t         hdr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      cnt_q    <= '0;
      hdr_q    <= '0;
    end else if (start_i) begin
      // new answered header wins over any stream in flight
      active_q <= 1'b1;
      idx_q    <= '0;
      hdr_q    <= hdr_i;
      if (!ack_i)       cnt_q <= CNT_W'(1);
      else if (cable_i) cnt_q <= CNT_W'(NUM_REGS + 1);
      else              cnt_q <= CNT_W'(NUM_REGS);
    end else if (active_q) begin
      if (idx_q == cnt_q - CNT_W'(1)) active_q <= 1'b0;
      else                            idx_q    <= idx_q + CNT_W'(1);
    end
  end

  always_comb begin
    tx_data_o = hdr_q;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx_q == CNT_W'(i + 1)) tx_data_o = regs_i[i];
    end
  end

  assign tx_valid_o = active_q;
  assign tx_first_o = active_q && (idx_q == '0);
  assign tx_last_o  = active_q && (idx_q == cnt_q - CNT_W'(1));
  assign tx_count_o = active_q ? cnt_q : '0;

  p_stream_cont_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_last_o && !start_i |=> tx_valid_o && !tx_first_o && $stable(tx_count_o));

  p_start_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> tx_valid_o && tx_first_o);

  p_nak_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_first_o && tx_data_o[7:6] == CT_NAK |-> tx_last_o && tx_count_o == CNT_W'(1));

  p_ack_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_first_o && tx_data_o[7:6] == CT_ACK |->
      tx_count_o == CNT_W'(NUM_REGS) || tx_count_o == CNT_W'(NUM_REGS + 1));

endmodule

// File: rtl/vdm_id_responder.sv
module vdm_id_responder
  import vdm_id_pkg::*;
#(
  parameter logic [15:0] PD_SID = 16'hFF00,
  parameter int          ADDR_W = 2,
  localparam int NUM_REGS = 1 << ADDR_W,
  localparam int CNT_W    = $clog2(NUM_REGS + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic              rx_first_i,
  input  logic [31:0]       rx_data_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic              tx_valid_o,
  output logic              tx_first_o,
  output logic              tx_last_o,
  output logic [31:0]       tx_data_o,
  output logic [CNT_W-1:0]  tx_count_o
);

  logic                      answer, ack;
  vdm_hdr_t                  resp_hdr;
  logic [NUM_REGS-1:0][31:0] regs;

  vdm_hdr_decode #(.PD_SID(PD_SID)) u_dec (
    .valid_i  (rx_valid_i),
    .first_i  (rx_first_i),
    .data_i   (rx_data_i),
    .answer_o (answer),
    .ack_o    (ack),
    .resp_o   (resp_hdr)
  );

  vdm_id_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .regs_o  (regs)
  );

  vdm_resp_seq #(.NUM_REGS(NUM_REGS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (answer),
    .ack_i      (ack),
    .cable_i    (is_cable(regs[0][29:27])),
    .hdr_i      (resp_hdr),
    .regs_i     (regs),
    .tx_valid_o (tx_valid_o),
    .tx_first_o (tx_first_o),
    .tx_last_o  (tx_last_o),
    .tx_data_o  (tx_data_o),
    .tx_count_o (tx_count_o)
  );

  p_unstructured_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_o && rx_valid_i && rx_first_i && !rx_data_i[15] |=> !tx_valid_o);

  p_non_init_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_o && rx_valid_i && rx_first_i && rx_data_i[7:6] != 2'b00 |=> !tx_valid_o);

  p_hdr_format_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_first_o |-> tx_data_o[15] && tx_data_o[14:8] == '0 && !tx_data_o[5]);

  p_never_init_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_first_o |-> tx_data_o[7:6] != 2'b00);

  p_body_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_o && !rx_first_i |=> !tx_valid_o);

endmodule

// File: tb/vdm_id_responder_tb.sv
`timescale 1ns/1ps
module vdm_id_responder_tb;

  typedef struct {
    logic [31:0] d;
    logic        first;
    logic        last;
    logic [2:0]  cnt;
    string       rq;
  } item_t;

  logic        clk = 0, rst_n = 0;
  logic        rx_valid = 0, rx_first = 0;
  logic [31:0] rx_data = '0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        tx_valid, tx_first, tx_last;
  logic [31:0] tx_data;
  logic [2:0]  tx_count;

  int checks = 0, errors = 0, unexp = 0;
  item_t exp_q[$];
  logic [31:0] m_regs [4];

  always #4 clk = ~clk;

  vdm_id_responder u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_first_i(rx_first), .rx_data_i(rx_data),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .tx_valid_o(tx_valid), .tx_first_o(tx_first), .tx_last_o(tx_last),
    .tx_data_o(tx_data), .tx_count_o(tx_count)
  );

  function automatic logic [31:0] mk(logic [15:0] svid, logic st, logic [1:0] ver,
                                     logic [2:0] pos, logic [1:0] ct, logic [4:0] cmd);
    return {svid, st, ver, 2'b11, pos, ct, 1'b1, cmd};
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (exp_q.size() == 0) begin
        unexp++; errors++;
        $display("FAIL unexpected object: actual %h expected none", tx_data);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        checks++;
        if (tx_data !== e.d || tx_first !== e.first || tx_last !== e.last || tx_count !== e.cnt) begin
          errors++;
          $display("FAIL %s: actual d=%h f=%b l=%b n=%0d expected d=%h f=%b l=%b n=%0d",
                   e.rq, tx_data, tx_first, tx_last, tx_count, e.d, e.first, e.last, e.cnt);
        end
      end
    end
  end

  task automatic check(input string rq, input logic ok, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, expv);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] v);
    logic [31:0] m;
    // R8 masks
    case (a)
      2'd0: m = 32'hFC00_FFFF;
      2'd1: m = 32'h000F_FFFF;
      2'd2: m = 32'hFFFF_FFFF;
      default: m = 32'hFF0F_FFFF;
    endcase
    cfg_we = 1; cfg_addr = a; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 0;
    m_regs[a] = v & m;
  endtask

  // drive one object; answered requests flush the aborted remainder (R10)
  task automatic send(input logic [31:0] hdr, input logic first, input string rq);
    logic answered, ack, cab;
    int n;
    logic [31:0] rh;
    rx_valid = 1; rx_first = first; rx_data = hdr;
    @(posedge clk); #1;
    rx_valid = 0; rx_first = 0;
    answered = first && hdr[15] && hdr[7:6] == 2'b00;
    if (answered) begin
      ack = hdr[31:16] == 16'hFF00 && hdr[4:0] == 5'd1;
      cab = m_regs[0][29:27] == 3'b011 || m_regs[0][29:27] == 3'b100;
      n   = !ack ? 1 : (cab ? 5 : 4);
      rh  = {hdr[31:16], 1'b1, 7'b0, ack ? 2'b01 : 2'b10, 1'b0, hdr[4:0]};
      exp_q.delete();
      for (int i = 0; i < n; i++) begin
        item_t it;
        it.d = (i == 0) ? rh : m_regs[i-1];
        it.first = (i == 0); it.last = (i == n-1); it.cnt = 3'(n);
        it.rq = rq;
        exp_q.push_back(it);
      end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(posedge clk);
    @(posedge clk); #1;
    check("drain", exp_q.size() == 0, 32'(exp_q.size()), 0);
  endtask

  task automatic idle_check(input string rq);
    int u0;
    u0 = unexp;
    repeat (8) @(posedge clk); #1;
    check(rq, unexp == u0 && !tx_valid, 32'(unexp - u0), 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_regs[i] = '0;
    repeat (3) @(posedge clk); #1;
    check("R1 reset idle", !tx_valid, {31'b0, tx_valid}, 0);
    rst_n = 1;
    @(posedge clk); #1;
    check("R1 idle after reset", !tx_valid, {31'b0, tx_valid}, 0);

    // R8 masked writes, product type 111 -> 4 objects (R6)
    cfg_write(0, 32'hFFFF_FFFF);
    cfg_write(1, 32'hFFFF_FFFF);
    cfg_write(2, 32'h1234_5678);
    cfg_write(3, 32'hFFFF_FFFF);
    send(mk(16'hFF00, 1, 2'b11, 3'b101, 2'b00, 5'd1), 1, "R4 R5 R6 R8 R9 ident 4obj");
    drain();

    // passive cable -> 5 objects
    cfg_write(0, 32'h9800_1234);
    cfg_write(1, 32'h000A_BCDE);
    send(mk(16'hFF00, 1, 2'b00, 3'b000, 2'b00, 5'd1), 1, "R4 R6 ident passive");
    drain();

    // active cable -> 5 objects
    cfg_write(0, 32'h6400_ABCD);
    cfg_write(3, 32'h1234_5671);
    send(mk(16'hFF00, 1, 2'b01, 3'b111, 2'b00, 5'd1), 1, "R4 R6 ident active");
    drain();

    // NAK cases R7
    send(mk(16'hFF00, 1, 2'b00, 3'b001, 2'b00, 5'd2), 1, "R7 nak svids");
    drain();
    send(mk(16'hFF00, 1, 2'b00, 3'b001, 2'b00, 5'd4), 1, "R7 nak enter");
    drain();
    send(mk(16'h1234, 1, 2'b00, 3'b000, 2'b00, 5'd1), 1, "R7 nak vid");
    drain();

    // dropped requests
    send(mk(16'hFF00, 0, 2'b00, 3'b000, 2'b00, 5'd1), 1, "R2");
    idle_check("R2 unstructured ignored");
    send(mk(16'hFF00, 1, 2'b00, 3'b000, 2'b01, 5'd1), 1, "R3");
    idle_check("R3 ack type dropped");
    send(mk(16'hFF00, 1, 2'b00, 3'b000, 2'b11, 5'd1), 1, "R3");
    idle_check("R3 busy type dropped");
    send(mk(16'hFF00, 1, 2'b00, 3'b000, 2'b00, 5'd1), 0, "R12");
    idle_check("R12 body object ignored");

    // dropped headers mid-stream leave it intact
    send(mk(16'hFF00, 1, 2'b00, 3'b000, 2'b00, 5'd1), 1, "R2 R3 stream intact");
    send(mk(16'hFF00, 0, 2'b00, 3'b000, 2'b00, 5'd1), 1, "R2");
    send(mk(16'hFF00, 1, 2'b00, 3'b000, 2'b10, 5'd1), 1, "R3");
    drain();

    // abort after first object
    send(mk(16'hFF00, 1, 2'b00, 3'b000, 2'b00, 5'd1), 1, "R10 first");
    send(mk(16'hFF00, 1, 2'b00, 3'b000, 2'b00, 5'd3), 1, "R10 abort early");
    drain();

    // abort with last object still pending
    send(mk(16'hFF00, 1, 2'b00, 3'b000, 2'b00, 5'd1), 1, "R10 first");
    repeat (3) @(posedge clk); #1;
    send(mk(16'hFF00, 1, 2'b00, 3'b000, 2'b00, 5'd6), 1, "R10 abort last");
    drain();

    // new request on the edge that ends the stream: back to back
    send(mk(16'hFF00, 1, 2'b00, 3'b000, 2'b00, 5'd1), 1, "R9 first");
    repeat (4) @(posedge clk); #1;
    send(mk(16'hFF00, 1, 2'b00, 3'b000, 2'b00, 5'd1), 1, "R9 R10 back to back");
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule